// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder, plus its once-per-turn index mark, into a 16-bit position count. Both phases and the index pass through a two-flop synchroniser. An edge decoder then classifies each sampled transition as a forward step, a reverse step or an invalid jump. A control register sets the update rate: in 4x rate every valid phase edge counts, and in 2x rate only edges on phase A count. The same register selects how the count is bounded. Either the index mark clears it, or it runs between zero and a programmable maximum count and wraps at that value.

Wrapping past a bound sets a sticky error flag, which only a register write clears. A direction flag reports whether the last counted edge was forward (A leading B) or reverse. Every counted edge also feeds a velocity prescaler. The prescaler emits a one-cycle pulse every 1, 4, 16 or 64 edges, so a downstream timer can measure speed. Software reaches the control register, the position count and the maximum count through a simple single-cycle read/write port.

Top module: `qenc_pos_unit`

## Requirements
- R1: After reset every register reads 0: control (mode 000, ratio 00, velocity-disable 0), error 0, direction 0, position 0 and maximum 0. In mode 000 and in the unused modes 011, 100 and 111, phase edges leave the position unchanged.
- R2: In 4x modes (101, 110), each valid edge on A or on B changes the position by one. Forward motion (phase sequence {A,B} = 00,10,11,01) increments the position and sets direction to 1. Reverse motion decrements it and sets direction to 0.
- R3: In 2x modes (001, 010), only edges on phase A change the position. Edges on B do not.
- R4: In index modes (001, 101), a rising edge on the index input clears the position to 0. In period modes (010, 110), the index input has no effect.
- R5: In period modes, counting up from a position equal to the maximum count gives 0, and counting down from 0 gives the maximum count. Both cases set the error flag.
- R6: In index modes, counting up from 0xFFFF gives 0 and counting down from 0 gives 0xFFFF. Both cases set the error flag.
- R7: The error flag stays set until software writes the control register with bit 6 = 0. Writing bit 6 = 1 neither clears nor sets it.
- R8: A sampled transition in which both A and B change at once is ignored. The position does not change.
- R9: When the velocity-disable bit (control bit 5) is 0 and the decoder is on, `vel_pulse` gives one single-cycle pulse for every N counted edges. The ratio field (bits 4:3) selects N: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. When bit 5 is 1, no pulses occur.
- R10: The velocity prescaler restarts from zero when the ratio field changes, when the decoder is off, and when velocity pulses are disabled.
- R11: Register map for `reg_addr`. Address 0 is control: bits 2:0 mode, 4:3 ratio, 5 velocity-disable, 6 error and 7 direction (read-only). Address 1 is the position (read/write). Address 2 is the maximum count (read/write). Address 3 reads 0. Unused bits read 0. A position write takes precedence over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| idx | input | 1 | Encoder index mark, asynchronous |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| vel_pulse | output | 1 | Decimated velocity pulse, one cycle wide |

## Verification
The situation that is hardest to reach from the ports is a velocity prescaler holding a partial count at the moment its ratio changes or the decoder is turned off. A clear that fails to happen is invisible until the next pulse arrives too early. To expose it, the bench walks the phases a few steps short of a pulse, then rewrites the ratio or toggles the mode off and on. It then counts the edges needed before the next pulse appears. The wrap cases are reached by writing the position directly next to a bound (the maximum count, zero or 0xFFFF) and taking a single step. The bench then reads back the position together with the error and direction bits.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam logic [2:0] MODE_OFF    = 3'b000;
    localparam logic [2:0] MODE_X2_IDX = 3'b001;
    localparam logic [2:0] MODE_X2_PER = 3'b010;
    localparam logic [2:0] MODE_X4_IDX = 3'b101;
    localparam logic [2:0] MODE_X4_PER = 3'b110;

    typedef struct packed {
        logic       vel_off;
        logic [1:0] ratio;
        logic [2:0] mode;
    } ctrl_t;

    function automatic logic mode_active(input logic [2:0] m);
        return (m == MODE_X2_IDX) || (m == MODE_X2_PER) ||
               (m == MODE_X4_IDX) || (m == MODE_X4_PER);
    endfunction

    function automatic logic mode_x4(input logic [2:0] m);
        return (m == MODE_X4_IDX) || (m == MODE_X4_PER);
    endfunction

    function automatic logic mode_period(input logic [2:0] m);
        return (m == MODE_X2_PER) || (m == MODE_X4_PER);
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
        end else begin
            st_q[0] <= din;
            for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/qenc_step.sv
module qenc_step (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    input  logic ix,
    input  logic x4,
    output logic cnt_en,
    output logic cnt_up,
    output logic idx_rise
);
    typedef struct packed {
        logic a;
        logic b;
        logic ix;
    } prev_t;

    prev_t prev_d, prev_q;
    logic  chg_a, chg_b;

    always_comb begin
        prev_d   = '{a: a, b: b, ix: ix};
        chg_a    = a ^ prev_q.a;
        chg_b    = b ^ prev_q.b;
        // exactly one phase moved; in 2x rate it must be phase A
        cnt_en   = (chg_a ^ chg_b) && (chg_a || x4);
        cnt_up   = chg_a ? (a != prev_q.b) : (b == a);
        idx_rise = ix && !prev_q.ix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    AST_BOTH_PHASES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_a && chg_b) |-> !cnt_en); // R8
endmodule

// File: rtl/qenc_vel.sv
module qenc_vel #(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               pulse
);
    localparam int DIV_W = 2 * ((1 << RATIO_W) - 1);

    typedef struct packed {
        logic [DIV_W-1:0]   cnt;
        logic [RATIO_W-1:0] last;
        logic               pls;
    } vel_t;

    vel_t             v_d, v_q;
    logic [DIV_W-1:0] lim;
    logic             clr;

    always_comb begin
        v_d      = v_q;
        v_d.pls  = 1'b0;
        v_d.last = ratio;
        lim      = DIV_W'((32'd1 << (32'(ratio) * 2)) - 32'd1);
        clr      = !run || (ratio != v_q.last);
        if (clr) begin
            v_d.cnt = '0;
        end else if (evt) begin
            if (v_q.cnt >= lim) begin
                v_d.cnt = '0;
                v_d.pls = 1'b1;
            end else begin
                v_d.cnt = v_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign pulse = v_q.pls;

    AST_VEL_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> !pulse); // R9
endmodule

// File: rtl/qenc_pos_unit.sv
module qenc_pos_unit #(
    parameter int POS_W  = 16,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic              idx,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              vel_pulse
);
    import qenc_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_MAX  = ADDR_W'(2);
    localparam int                ERR_B  = $bits(ctrl_t);
    localparam int                DIR_B  = ERR_B + 1;

    typedef struct packed {
        ctrl_t            ctrl;
        logic             err;
        logic             dir;
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] maxc;
    } state_t;

    state_t           s_d, s_q;
    logic [2:0]       syn;
    logic             cnt_en, cnt_up, idx_rise;
    logic             active, period, step_en, idx_clr, err_set, err_clr;
    logic             wr_ctrl, wr_pos;
    logic [POS_W-1:0] top_val;

    qenc_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
        .clk (clk), .rst_n (rst_n), .din ({idx, ph_b, ph_a}), .dout (syn)
    );

    qenc_step u_step (
        .clk (clk), .rst_n (rst_n), .a (syn[0]), .b (syn[1]), .ix (syn[2]),
        .x4 (mode_x4(s_q.ctrl.mode)), .cnt_en (cnt_en), .cnt_up (cnt_up),
        .idx_rise (idx_rise)
    );

    qenc_vel #(.RATIO_W(2)) u_vel (
        .clk (clk), .rst_n (rst_n), .evt (step_en),
        .run (active && !s_q.ctrl.vel_off), .ratio (s_q.ctrl.ratio),
        .pulse (vel_pulse)
    );

    always_comb begin
        s_d     = s_q;
        active  = mode_active(s_q.ctrl.mode);
        period  = mode_period(s_q.ctrl.mode);
        step_en = active && cnt_en;
        idx_clr = active && !period && idx_rise;
        top_val = period ? s_q.maxc : '1;
        wr_ctrl = reg_wr && (reg_addr == A_CTRL);
        wr_pos  = reg_wr && (reg_addr == A_POS);
        err_set = 1'b0;
        err_clr = wr_ctrl && !reg_wdata[ERR_B];

        if (step_en) begin
            s_d.dir = cnt_up;
            if (cnt_up) begin
                if (s_q.pos == top_val) begin
                    s_d.pos = '0;
                    err_set = 1'b1;
                end else begin
                    s_d.pos = s_q.pos + 1'b1;
                end
            end else begin
                if (s_q.pos == '0) begin
                    s_d.pos = top_val;
                    err_set = 1'b1;
                end else begin
                    s_d.pos = s_q.pos - 1'b1;
                end
            end
        end
        if (idx_clr) s_d.pos = '0;

        if (wr_ctrl) s_d.ctrl = ctrl_t'(reg_wdata[ERR_B-1:0]);
        if (wr_pos)  s_d.pos  = reg_wdata[POS_W-1:0];
        if (reg_wr && (reg_addr == A_MAX)) s_d.maxc = reg_wdata[POS_W-1:0];
        s_d.err = err_set || (s_q.err && !err_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[ERR_B-1:0] = s_q.ctrl;
                reg_rdata[ERR_B]     = s_q.err;
                reg_rdata[DIR_B]     = s_q.dir;
            end
            A_POS:   reg_rdata = DATA_W'(s_q.pos);
            A_MAX:   reg_rdata = DATA_W'(s_q.maxc);
            default: reg_rdata = '0;
        endcase
    end

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_pos) |=> (s_q.pos == $past(s_q.pos))); // R1
    AST_IDX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_clr && !wr_pos) |=> (s_q.pos == '0)); // R4
    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cnt_up && (s_q.pos == top_val)) |=> s_q.err); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !err_clr) |=> s_q.err); // R7
endmodule

// File: tb/qenc_pos_unit_test.sv
`timescale 1ns/1ps
module qenc_pos_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ph_a = 1'b0, ph_b = 1'b0, idx = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        vel_pulse;

    int checks = 0;
    int errors = 0;
    int pcnt   = 0;
    int ph     = 0;

    always #2.5 clk = ~clk;

    qenc_pos_unit uut (
        .clk (clk), .rst_n (rst_n), .ph_a (ph_a), .ph_b (ph_b), .idx (idx),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .vel_pulse (vel_pulse)
    );

    always @(negedge clk) if (vel_pulse) pcnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drive_ph();
        case (ph)
            0: {ph_a, ph_b} = 2'b00;
            1: {ph_a, ph_b} = 2'b10;
            2: {ph_a, ph_b} = 2'b11;
            default: {ph_a, ph_b} = 2'b01;
        endcase
        repeat (4) @(negedge clk);
    endtask

    task automatic go(input bit fwd, input int n);
        for (int i = 0; i < n; i++) begin
            ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
            drive_ph();
        end
    endtask

    task automatic idx_pulse();
        idx = 1'b1; repeat (4) @(negedge clk);
        idx = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); chk("R1 ctrl after reset", v, 0);
        rd(2'd1, v); chk("R1 pos after reset", v, 0);
        rd(2'd2, v); chk("R1 max after reset", v, 0);
        rd(2'd3, v); chk("R11 addr3 reads 0", v, 0);
    endtask

    task automatic t_off();
        logic [15:0] v;
        go(1, 4); rd(2'd1, v); chk("R1 off mode holds", v, 0);
        wr(2'd0, 16'h0023); go(1, 4); rd(2'd1, v); chk("R1 mode 011 idle", v, 0);
        wr(2'd0, 16'h0024); go(1, 4); rd(2'd1, v); chk("R1 mode 100 idle", v, 0);
        wr(2'd0, 16'h0027); go(0, 4); rd(2'd1, v); chk("R1 mode 111 idle", v, 0);
    endtask

    task automatic t_x4();
        logic [15:0] v;
        wr(2'd0, 16'h0025); wr(2'd1, 16'd0);
        go(1, 8); rd(2'd1, v); chk("R2 4x forward count", v, 8);
        rd(2'd0, v); chk("R2 dir forward", v[7], 1);
        go(0, 3); rd(2'd1, v); chk("R2 4x reverse count", v, 5);
        rd(2'd0, v); chk("R2 dir reverse", v[7], 0);
    endtask

    task automatic t_x2();
        logic [15:0] v;
        wr(2'd0, 16'h0021); wr(2'd1, 16'd0);
        go(1, 8); rd(2'd1, v); chk("R3 2x counts A edges only", v, 4);
        go(0, 4); rd(2'd1, v); chk("R3 2x reverse", v, 2);
    endtask

    task automatic t_invalid();
        logic [15:0] v;
        wr(2'd0, 16'h0025); wr(2'd1, 16'd10);
        ph = (ph + 2) % 4; drive_ph();
        rd(2'd1, v); chk("R8 double change ignored", v, 10);
        go(1, 1); rd(2'd1, v); chk("R8 normal step after jump", v, 11);
    endtask

    task automatic t_index();
        logic [15:0] v;
        wr(2'd0, 16'h0025); wr(2'd1, 16'd100);
        idx_pulse(); rd(2'd1, v); chk("R4 index clears position", v, 0);
        wr(2'd0, 16'h0026); wr(2'd2, 16'd1000); wr(2'd1, 16'd7);
        idx_pulse(); rd(2'd1, v); chk("R4 index ignored in period mode", v, 7);
    endtask

    task automatic t_period_wrap();
        logic [15:0] v;
        wr(2'd0, 16'h0026); wr(2'd2, 16'd5); wr(2'd1, 16'd5);
        go(1, 1); rd(2'd1, v); chk("R5 up from max gives 0", v, 0);
        rd(2'd0, v); chk("R11 ctrl readback err+dir", v, 16'h00E6);
        wr(2'd0, 16'h0026); rd(2'd0, v); chk("R7 write 0 clears error", v, 16'h00A6);
        go(0, 1); rd(2'd1, v); chk("R5 down from 0 gives max", v, 5);
        rd(2'd0, v); chk("R5 underflow error, dir reverse", v, 16'h0066);
    endtask

    task automatic t_index_wrap();
        logic [15:0] v;
        wr(2'd0, 16'h0025); wr(2'd1, 16'hFFFF);
        go(1, 1); rd(2'd1, v); chk("R6 up from FFFF gives 0", v, 0);
        rd(2'd0, v); chk("R6 overflow error", v[6], 1);
        wr(2'd0, 16'h0025); go(0, 1); rd(2'd1, v); chk("R6 down from 0 gives FFFF", v, 16'hFFFF);
        rd(2'd0, v); chk("R6 underflow error", v[6], 1);
    endtask

    task automatic t_sticky();
        logic [15:0] v;
        wr(2'd0, 16'h0065); rd(2'd0, v); chk("R7 write 1 keeps error", v[6], 1);
        go(0, 2); rd(2'd0, v); chk("R7 error survives counting", v[6], 1);
        wr(2'd0, 16'h0025); rd(2'd0, v); chk("R7 write 0 clears", v[6], 0);
        wr(2'd0, 16'h0065); rd(2'd0, v); chk("R7 write 1 does not set", v[6], 0);
    endtask

    task automatic t_vel();
        for (int r = 0; r < 4; r++) begin
            int n = 1 << (2 * r);
            wr(2'd0, 16'(5 | (r << 3)));
            pcnt = 0;
            go(1, 2 * n); chk($sformatf("R9 pulses at ratio %0d", r), pcnt, 2);
            if (n > 1) begin
                go(1, n - 1); chk($sformatf("R9 no early pulse ratio %0d", r), pcnt, 2);
            end
        end
        wr(2'd0, 16'h0020 | 16'h0005); pcnt = 0;
        go(1, 8); chk("R9 disabled gives no pulse", pcnt, 0);
    endtask

    task automatic t_prescale_clear();
        wr(2'd0, 16'h0005); wr(2'd0, 16'h000D);
        pcnt = 0; go(1, 3); chk("R10 no pulse before 4", pcnt, 0);
        wr(2'd0, 16'h0015); wr(2'd0, 16'h000D);
        go(1, 1); chk("R10 ratio change cleared prescaler", pcnt, 0);
        go(1, 2); chk("R10 still short of 4", pcnt, 0);
        go(1, 1); chk("R10 pulse after 4 fresh edges", pcnt, 1);
        pcnt = 0; go(1, 3);
        wr(2'd0, 16'h0008); wr(2'd0, 16'h000D);
        go(1, 1); chk("R10 off cleared prescaler", pcnt, 0);
        go(1, 3); chk("R10 pulse after restart", pcnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_x4();
        t_x2();
        t_invalid();
        t_index();
        t_period_wrap();
        t_index_wrap();
        t_sticky();
        t_vel();
        t_prescale_clear();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule